// File: doc/BRIEF.md
# Subcarrier Quadrature Phase Generator

This block turns a clock running at four times the colour subcarrier into the reference phases used by a video encoder's colour modulators. A two-bit counter advances one quarter turn per clock, so each of its four codes marks one of the phases 0, 90, 180 and 270 degrees. From that counter the block derives the carrier phase for the U modulator, the V modulator and the colour burst, each as a two-bit code. A line-alternation flag is also produced for the line-by-line V inversion that PAL needs.

In PAL operation the V carrier moves between 90 and 270 degrees on successive lines, driven by a per-line strobe. In NTSC operation it stays at 90 degrees. A frame strobe can pull the counter back to phase 0 and clear the alternation flag. Depending on a mode input, this realignment happens on every frame or only on every fourth frame. When sync is generated from the same clock, the realignment lands on phase 0 anyway and is invisible. When sync is not derived from that clock, it causes a phase step.

Top module: `subcarrier_phase_gen`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to u_phase = 0, v_phase = 1, burst_phase = 2 and pal_alt_flag = 0, and its frame count is cleared.
- R2: Phase codes mean 0 = 0°, 1 = 90°, 2 = 180° and 3 = 270°. u_phase is the reference and, with no realignment, it increases by one (modulo 4) on every clock.
- R3: With ntsc_sel = 1, v_phase always equals u_phase + 1 (modulo 4).
- R4: With ntsc_sel = 0, v_phase equals u_phase + 1 while pal_alt_flag = 0 and u_phase + 3 while pal_alt_flag = 1 (all modulo 4).
- R5: burst_phase always equals u_phase + 2 (modulo 4). In PAL, its line-dependent component is given by pal_alt_flag.
- R6: With ntsc_sel = 0, a cycle with line_strobe high and no realignment inverts pal_alt_flag on the next edge. With ntsc_sel = 1, pal_alt_flag holds its value.
- R7: With realign_each_frame = 1, every frame_strobe makes u_phase = 0 and pal_alt_flag = 0 after that edge.
- R8: With realign_each_frame = 0, only the frame_strobe that wraps the 2-bit frame count from 3 to 0 realigns, which is every fourth strobe since reset. The other frame strobes leave the phase and the flag running.
- R9: When line_strobe and a realigning frame_strobe fall in the same cycle, the realignment wins and pal_alt_flag becomes 0.
- R10: The frame count advances on every frame_strobe in both realignment modes, so a switch to four-frame mode continues from the count already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the subcarrier frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| ntsc_sel | input | 1 | 1 selects NTSC, 0 selects PAL |
| realign_each_frame | input | 1 | 1 realigns on every frame, 0 on every fourth frame |
| line_strobe | input | 1 | One-cycle pulse per valid line |
| frame_strobe | input | 1 | One-cycle pulse at each frame start |
| u_phase | output | PHASE_W | U carrier phase code |
| v_phase | output | PHASE_W | V carrier phase code |
| burst_phase | output | PHASE_W | Burst carrier phase code |
| pal_alt_flag | output | 1 | PAL line-alternation state, 0 means V at +90° |

## Verification
Two events can land on the same clock edge: a line strobe that would flip the PAL alternation flag, and a frame strobe that realigns the counter and clears that flag. The bench drives both strobes together in PAL mode. It does this in every-frame mode and also on the wrapping strobe of four-frame mode. After that edge it expects a zero phase and a cleared flag. It also drives both strobes together on a non-wrapping four-frame strobe, where the flag must toggle and the phase must keep running. A behavioural model compares u, v, burst and the flag on every clock, so a wrong precedence shows up in the v_phase offset of the following line.

// File: rtl/sc_phase_pkg.sv
// Shared constants for the subcarrier phase generator.
// Assumes phase codes count quarter turns of the subcarrier.
package sc_phase_pkg;
    localparam int SC_DEF_PHASE_W = 2;   // quarter-turn resolution
    localparam int SC_DEF_FRAME_W = 2;   // frame counter width (period 4)
    localparam int SC_CARRIERS    = 3;   // U, V, burst
    typedef enum logic [1:0] {
        CAR_U     = 2'd0,
        CAR_V     = 2'd1,
        CAR_BURST = 2'd2
    } carrier_e;
endpackage

// File: rtl/sc_quadrature_counter.sv
// Divide-by-2**PHASE_W phase counter: advances one code per clock and
// returns to zero when realign is high. Assumes realign is synchronous.
module sc_quadrature_counter #(
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               realign,
    output logic [PHASE_W-1:0] phase
);
    localparam logic [PHASE_W-1:0] STEP = PHASE_W'(1);

    // Phase accumulation with realignment to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || realign)
            phase <= '0;
        else
            phase <= phase + STEP;
    end
endmodule

// File: rtl/sc_frame_sequencer.sv
// Counts frame strobes and decides when the phase counter is realigned:
// on every strobe, or only on the strobe that wraps the count to zero.
// Assumes frame_strobe lasts one cycle per frame.
module sc_frame_sequencer #(
    parameter int FRAME_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_strobe,
    input  logic each_frame,
    output logic realign
);
    localparam logic [FRAME_W-1:0] LAST = {FRAME_W{1'b1}};
    localparam logic [FRAME_W-1:0] INC  = FRAME_W'(1);

    logic [FRAME_W-1:0] frame_cnt;

    // Frame counter runs in both modes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_cnt <= '0;
        else if (frame_strobe)
            frame_cnt <= frame_cnt + INC;
    end

    // Realign decision for the current strobe.
    always_comb begin
        realign = frame_strobe && (each_frame || frame_cnt == LAST);
    end
endmodule

// File: rtl/sc_line_alternator.sv
// PAL line-alternation flag: flips on each line strobe in PAL, holds in
// NTSC, and is cleared by realignment, which takes precedence.
module sc_line_alternator (
    input  logic clk,
    input  logic rst_n,
    input  logic pal_mode,
    input  logic line_strobe,
    input  logic realign,
    output logic alt
);
    // Flag update with realignment precedence.
    always_ff @(posedge clk) begin
        if (!rst_n || realign)
            alt <= 1'b0;
        else if (pal_mode && line_strobe)
            alt <= ~alt;
    end
endmodule

// File: rtl/sc_carrier_map.sv
// Maps the reference phase to the carrier phases by adding a per-carrier
// quarter-turn offset. The V offset follows the PAL alternation flag.
module sc_carrier_map
    import sc_phase_pkg::*;
#(
    parameter int PHASE_W = 2
) (
    input  logic               [PHASE_W-1:0] ref_phase,
    input  logic                             pal_mode,
    input  logic                             alt,
    output logic [SC_CARRIERS-1:0][PHASE_W-1:0] carrier
);
    localparam logic [PHASE_W-1:0] QTR  = PHASE_W'(1 << (PHASE_W - 2));
    localparam logic [PHASE_W-1:0] HALF = PHASE_W'(2 * (1 << (PHASE_W - 2)));
    localparam logic [PHASE_W-1:0] TQTR = PHASE_W'(3 * (1 << (PHASE_W - 2)));

    logic [SC_CARRIERS-1:0][PHASE_W-1:0] offset;

    // Offset per carrier: U at 0, V at +90 or +270, burst at 180.
    always_comb begin
        offset            = '0;
        offset[CAR_U]     = '0;
        offset[CAR_V]     = (pal_mode && alt) ? TQTR : QTR;
        offset[CAR_BURST] = HALF;
    end

    for (genvar c = 0; c < SC_CARRIERS; c++) begin : g_car
        // Carrier phase is the reference rotated by its offset.
        always_comb carrier[c] = ref_phase + offset[c];
    end
endmodule

// File: rtl/subcarrier_phase_gen.sv
// Subcarrier quadrature phase generator top: divides the 4x subcarrier
// clock into quarter-turn phase codes for U, V and burst, with PAL line
// alternation and per-frame or four-frame realignment.
// Assumes line and frame strobes are synchronous one-cycle pulses.
module subcarrier_phase_gen
    import sc_phase_pkg::*;
#(
    parameter int PHASE_W = SC_DEF_PHASE_W,
    parameter int FRAME_W = SC_DEF_FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ntsc_sel,
    input  logic               realign_each_frame,
    input  logic               line_strobe,
    input  logic               frame_strobe,
    output logic [PHASE_W-1:0] u_phase,
    output logic [PHASE_W-1:0] v_phase,
    output logic [PHASE_W-1:0] burst_phase,
    output logic               pal_alt_flag
);
    logic                                realign;
    logic [PHASE_W-1:0]                  ref_phase;
    logic                                pal_mode;
    logic [SC_CARRIERS-1:0][PHASE_W-1:0] carrier;

    // PAL is the inverse of the standard select.
    always_comb pal_mode = ~ntsc_sel;

    sc_frame_sequencer #(.FRAME_W(FRAME_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .each_frame(realign_each_frame), .realign(realign)
    );

    sc_quadrature_counter #(.PHASE_W(PHASE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .realign(realign), .phase(ref_phase)
    );

    sc_line_alternator u_alt (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode),
        .line_strobe(line_strobe), .realign(realign), .alt(pal_alt_flag)
    );

    sc_carrier_map #(.PHASE_W(PHASE_W)) u_map (
        .ref_phase(ref_phase), .pal_mode(pal_mode), .alt(pal_alt_flag),
        .carrier(carrier)
    );

    // Output selection from the carrier bundle.
    always_comb begin
        u_phase     = carrier[CAR_U];
        v_phase     = carrier[CAR_V];
        burst_phase = carrier[CAR_BURST];
    end
endmodule

// File: rtl/sc_phase_checker.sv
// Port-level properties of the subcarrier phase generator.
module sc_phase_checker #(
    parameter int PHASE_W = 2,
    parameter int FRAME_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ntsc_sel,
    input logic               realign_each_frame,
    input logic               line_strobe,
    input logic               frame_strobe,
    input logic [PHASE_W-1:0] u_phase,
    input logic [PHASE_W-1:0] v_phase,
    input logic [PHASE_W-1:0] burst_phase,
    input logic               pal_alt_flag
);
    localparam logic [PHASE_W-1:0] ONE  = PHASE_W'(1);
    localparam logic [PHASE_W-1:0] QTR  = PHASE_W'(1 << (PHASE_W - 2));
    localparam logic [PHASE_W-1:0] HALF = PHASE_W'(2 * (1 << (PHASE_W - 2)));
    localparam logic [PHASE_W-1:0] TQTR = PHASE_W'(3 * (1 << (PHASE_W - 2)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (u_phase == '0 && !pal_alt_flag));

    // R2
    phase_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> u_phase == $past(u_phase) + ONE);

    // R3
    ntsc_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntsc_sel |-> v_phase == u_phase + QTR);

    // R4
    pal_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ntsc_sel |-> v_phase == u_phase + (pal_alt_flag ? TQTR : QTR));

    // R5
    burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_phase == u_phase + HALF);

    // R6
    pal_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ntsc_sel && line_strobe && !frame_strobe) |=>
            pal_alt_flag != $past(pal_alt_flag));

    // R6
    ntsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ntsc_sel && !frame_strobe) |=> $stable(pal_alt_flag));

    // R7
    each_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && realign_each_frame) |=>
            (u_phase == '0 && !pal_alt_flag));
endmodule

bind subcarrier_phase_gen sc_phase_checker #(
    .PHASE_W(PHASE_W), .FRAME_W(FRAME_W)
) u_chk (.*);

// File: tb/sim_subcarrier_phase_gen.sv
module sim_subcarrier_phase_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ntsc_sel = 1'b1;
    logic       realign_each_frame = 1'b1;
    logic       line_strobe = 1'b0;
    logic       frame_strobe = 1'b0;
    logic [1:0] u_phase, v_phase, burst_phase;
    logic       pal_alt_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int m_ph = 0, m_alt = 0, m_fc = 0;

    subcarrier_phase_gen u0 (
        .clk(clk), .rst_n(rst_n), .ntsc_sel(ntsc_sel),
        .realign_each_frame(realign_each_frame), .line_strobe(line_strobe),
        .frame_strobe(frame_strobe), .u_phase(u_phase), .v_phase(v_phase),
        .burst_phase(burst_phase), .pal_alt_flag(pal_alt_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        bit re;
        if (!rst_n) begin
            m_ph = 0; m_alt = 0; m_fc = 0;
        end else begin
            re = frame_strobe && (realign_each_frame || m_fc == 3);
            if (frame_strobe) m_fc = (m_fc + 1) % 4;        // R10
            if (re) begin
                m_ph = 0; m_alt = 0;                        // R7 R8 R9
            end else begin
                m_ph = (m_ph + 1) % 4;                      // R2
                if (!ntsc_sel && line_strobe) m_alt = 1 - m_alt; // R6
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model
    task automatic compare();
        int ev;
        ev = ntsc_sel ? (m_ph + 1) % 4 : (m_ph + (m_alt ? 3 : 1)) % 4;
        chk("R2/R7/R8 u_phase", int'(u_phase), m_ph);
        chk("R3/R4 v_phase", int'(v_phase), ev);
        chk("R5 burst_phase", int'(burst_phase), (m_ph + 2) % 4);
        chk("R6/R9 pal_alt_flag", int'(pal_alt_flag), m_alt);
    endtask

    // One cycle: check at the falling edge, then drive the next inputs
    task automatic step(input bit ls, input bit fs);
        @(negedge clk);
        if (rst_n) compare();
        line_strobe  = ls;
        frame_strobe = fs;
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < WATCHDOG) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", wd, WATCHDOG);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 u_phase", int'(u_phase), 0);
        chk("R1 v_phase", int'(v_phase), 1);
        chk("R1 burst_phase", int'(burst_phase), 2);
        chk("R1 pal_alt_flag", int'(pal_alt_flag), 0);
        rst_n = 1'b1;

        // R2 R3: NTSC free run with line strobes (flag must hold)
        for (int i = 0; i < 40; i++) step(i % 7 == 0, 1'b0);

        // R4 R6: PAL with line strobes at varied spacing
        ntsc_sel = 1'b0;
        for (int i = 0; i < 60; i++) step((i % 5 == 0) || (i % 11 == 3), 1'b0);

        // R7: every-frame realignment at different phases
        realign_each_frame = 1'b1;
        for (int i = 0; i < 30; i++) step(i % 4 == 1, i % 9 == 5);

        // R9: coincident strobes in every-frame mode
        for (int i = 0; i < 6; i++) step(1'b1, i == 2);

        // R10: switch to four-frame mode with the count already advanced
        realign_each_frame = 1'b0;
        // R8: only the wrapping strobe realigns; coincident strobes included
        for (int i = 0; i < 120; i++) step(i % 3 == 0, i % 13 == 6);

        // R3: back to NTSC, flag holds, four-frame strobes continue
        ntsc_sel = 1'b1;
        for (int i = 0; i < 60; i++) step(i % 2 == 0, i % 10 == 4);

        // Random mix of modes and strobes
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) begin
                ntsc_sel = 1'($urandom_range(0, 1));
                realign_each_frame = 1'($urandom_range(0, 1));
            end
            step(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 7) == 0));
        end

        // R1: reset mid-run returns to the reset state
        @(negedge clk);
        rst_n = 1'b0;
        line_strobe = 1'b0;
        frame_strobe = 1'b0;
        @(negedge clk);
        chk("R1 u_phase after reset", int'(u_phase), 0);
        chk("R1 pal_alt_flag after reset", int'(pal_alt_flag), 0);
        rst_n = 1'b1;
        // R8: frame count was cleared, so the fourth strobe realigns
        ntsc_sel = 1'b0;
        realign_each_frame = 1'b0;
        for (int i = 0; i < 40; i++) step(i % 2 == 1, i % 6 == 2);
        step(1'b0, 1'b0);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule